// File: doc/BRIEF.md
# Stereo Serial Audio Receiver

This block takes stereo audio from a three-wire serial link: a bit clock, a word clock that marks the left and right channels, and a single data line. The three wires are brought into the system clock domain through two-stage synchronisers. Each data bit is taken on a rising edge of the bit clock as seen in that domain. The bit clock may stop for any time between edges, so capture never relies on it running freely. Words arrive most significant bit first as two's complement values of 16, 18, 20 or 24 bits, chosen by a 2-bit length code. A 2-bit framing code selects one of four ways to place the words inside each word-clock period.

After the right-channel word of a frame is complete, the block puts the left and right samples, sign-extended to 24 bits, on two parallel outputs. It also raises a valid strobe for one system clock. Each channel has its own long-silence flag. The flag goes high once that channel has carried only zero samples for more than a set number of word-clock periods, and it drops on the first nonzero sample. The framing and length codes are meant to be changed only while the block is held in reset.

Top module: `ser_audio_rx`

## Requirements
- R1: With framing code 2'b00 (left-justified), the word clock is high for the left channel and low for the right. The channel's MSB is the bit taken at the first rising bit-clock edge after the word clock changes level.
- R2: With framing code 2'b01 (I2S style), the word clock is low for the left channel and high for the right. The MSB is the bit taken one bit-clock edge after the edge at which the level change is first seen.
- R3: With framing code 2'b10 (right-justified), the word clock is high for the left channel and low for the right. A channel's word is its last N bits before the word clock changes level. The pair is published when the right half-period ends.
- R4: With framing code 2'b11 (frame-pulse style), a rising edge of the word clock, seen at a bit-clock edge, marks a frame. The left MSB is taken at the next bit-clock edge, and the right MSB directly follows the left LSB.
- R5: Length code 2'b00, 2'b01, 2'b10 and 2'b11 gives N = 16, 18, 20 and 24 bits. Each word is two's complement, MSB first, and is presented sign-extended to 24 bits.
- R6: Data bits outside the N-bit word of each channel have no effect on the outputs.
- R7: out_valid is a single system-clock pulse, once per frame, after the right word completes. out_left and out_right change only with that pulse.
- R8: Pauses of any length in the bit clock between rising edges do not change what is captured.
- R9: A channel's zero flag rises once that channel has received more than ZERO_RUN consecutive all-zero samples. It stays high during longer runs because its counter saturates.
- R10: A zero flag clears at the first nonzero sample of its channel.
- R11: While rst_n is low, out_left, out_right, out_valid, zero_left and zero_right are all 0, and capture starts afresh once rst_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-down/reset |
| bclk_in | input | 1 | Serial bit clock, may be gated |
| lrck_in | input | 1 | Word clock or frame pulse |
| sdin | input | 1 | Serial data, MSB first |
| fmt | input | 2 | Framing code (R1 to R4) |
| wlen | input | 2 | Word length code (R5) |
| out_left | output | 24 | Left sample, sign-extended |
| out_right | output | 24 | Right sample, sign-extended |
| out_valid | output | 1 | One-cycle strobe for a new pair |
| zero_left | output | 1 | Left channel long-silence flag |
| zero_right | output | 1 | Right channel long-silence flag |

## Verification
The bench builds the block with ZERO_RUN set to 6 instead of 1024. At that value the flag's rise after seven zero samples, its clearing, and saturation past the counter's natural wrap point can all be reached in a few dozen frames. The default 1024 would need thousands of frames. All sixteen pairings of framing and length code are driven with random bit-clock pauses and random filler outside each word, so the capture window is checked at every width in every framing.

// File: rtl/ser_audio_rx.sv
module ser_audio_rx #(
  parameter int ZERO_RUN = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bclk_in,
  input  logic        lrck_in,
  input  logic        sdin,
  input  logic [1:0]  fmt,
  input  logic [1:0]  wlen,
  output logic [23:0] out_left,
  output logic [23:0] out_right,
  output logic        out_valid,
  output logic        zero_left,
  output logic        zero_right
);
  localparam int ZMAX = ZERO_RUN + 1;
  localparam int ZCW  = $clog2(ZMAX + 1);
  localparam logic [1:0] F_LJ = 2'd0, F_I2S = 2'd1, F_RJ = 2'd2, F_DSP = 2'd3;

  function automatic logic [23:0] sext(input logic [23:0] v, input logic [1:0] wl);
    case (wl)
      2'd0:    return {{8{v[15]}}, v[15:0]};
      2'd1:    return {{6{v[17]}}, v[17:0]};
      2'd2:    return {{4{v[19]}}, v[19:0]};
      default: return v;
    endcase
  endfunction

  logic [2:0] b_sr;
  logic [1:0] l_sr, d_sr;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      b_sr <= '0; l_sr <= '0; d_sr <= '0;
    end else begin
      b_sr <= {b_sr[1:0], bclk_in};
      l_sr <= {l_sr[0], lrck_in};
      d_sr <= {d_sr[0], sdin};
    end

  wire rise = b_sr[1] & ~b_sr[2];
  wire lr_s = l_sr[1];
  wire d_s  = d_sr[1];

  logic        lr_q, pend, pch, act, chan;
  logic [4:0]  cnt;
  logic [23:0] sh, lhold;
  logic [ZCW-1:0] zc_l, zc_r;

  wire        lr_chg = lr_s ^ lr_q;
  wire [23:0] sh_nx  = {sh[22:0], d_s};
  wire [4:0]  wbits  = (wlen == 2'd0) ? 5'd16 : (wlen == 2'd1) ? 5'd18 :
                       (wlen == 2'd2) ? 5'd20 : 5'd24;

  logic        start, stch, done, dch, pend_n, pch_n;
  logic [4:0]  cnt_n;
  logic [23:0] dword;

  always_comb begin
    start = 1'b0;
    stch  = 1'b0;
    if (fmt == F_LJ && lr_chg) begin
      start = 1'b1;
      stch  = ~lr_s;
    end else if ((fmt == F_I2S || fmt == F_DSP) && pend) begin
      start = 1'b1;
      stch  = pch;
    end
    cnt_n = start ? 5'd1 : cnt + 5'd1;
    if (fmt == F_RJ) begin
      done  = lr_chg;
      dch   = lr_s;
      dword = sh;
    end else begin
      done  = (start | act) && (cnt_n == wbits);
      dch   = start ? stch : chan;
      dword = sh_nx;
    end
    pend_n = 1'b0;
    pch_n  = 1'b0;
    if (fmt == F_I2S) begin
      pend_n = lr_chg;
      pch_n  = lr_s;
    end else if (fmt == F_DSP) begin
      if (lr_s && !lr_q) begin
        pend_n = 1'b1;
      end else if (done && !dch) begin
        pend_n = 1'b1;
        pch_n  = 1'b1;
      end
    end
  end

  wire [23:0] wsx = sext(dword, wlen);
  wire        wz  = (wsx == '0);

  logic [ZCW-1:0] zc_l_n, zc_r_n;
  always_comb begin
    zc_l_n = zc_l;
    zc_r_n = zc_r;
    if (rise && done && !dch)
      zc_l_n = !wz ? '0 : (int'(zc_l) >= ZMAX) ? zc_l : zc_l + 1'b1;
    if (rise && done && dch)
      zc_r_n = !wz ? '0 : (int'(zc_r) >= ZMAX) ? zc_r : zc_r + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lr_q <= 1'b0; pend <= 1'b0; pch <= 1'b0; act <= 1'b0; chan <= 1'b0;
      cnt <= '0; sh <= '0; lhold <= '0;
      out_left <= '0; out_right <= '0; out_valid <= 1'b0;
      zc_l <= '0; zc_r <= '0; zero_left <= 1'b0; zero_right <= 1'b0;
    end else begin
      out_valid  <= 1'b0;
      zc_l       <= zc_l_n;
      zc_r       <= zc_r_n;
      zero_left  <= int'(zc_l_n) > ZERO_RUN;
      zero_right <= int'(zc_r_n) > ZERO_RUN;
      if (rise) begin
        lr_q <= lr_s;
        pend <= pend_n;
        pch  <= pch_n;
        if (fmt == F_RJ || start || act) sh <= sh_nx;
        if (start || act) cnt <= cnt_n;
        act <= (start | act) & ~done & (fmt != F_RJ);
        if (start) chan <= stch;
        if (done && !dch) lhold <= dword;
        if (done && dch) begin
          out_left  <= sext(lhold, wlen);
          out_right <= wsx;
          out_valid <= 1'b1;
        end
      end
    end

  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_left) && $stable(out_right)));
  p_sext16_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && wlen == 2'd0) |-> (&out_left[23:15] || ~|out_left[23:15]));
  p_zrise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_left) |-> $past(rise));
  p_zclear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && done && !dch && !wz) |=> !zero_left);
endmodule

// File: tb/ser_audio_rx_test.sv
`timescale 1ns/1ps
module ser_audio_rx_test;
  localparam int ZR = 6;

  logic clk = 1'b0, rst_n = 1'b0, bclk_in = 1'b0, lrck_in = 1'b0, sdin = 1'b0;
  logic [1:0] fmt = 2'd0, wlen = 2'd0;
  logic [23:0] out_left, out_right;
  logic out_valid, zero_left, zero_right;

  always #2.5 clk = ~clk;

  ser_audio_rx #(.ZERO_RUN(ZR)) uut (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .lrck_in(lrck_in), .sdin(sdin),
    .fmt(fmt), .wlen(wlen), .out_left(out_left), .out_right(out_right),
    .out_valid(out_valid), .zero_left(zero_left), .zero_right(zero_right));

  int checks = 0, fails = 0, vcnt = 0;

  always @(negedge clk) if (rst_n && out_valid) vcnt++;

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int wbits(input logic [1:0] wl);
    return (wl == 2'd0) ? 16 : (wl == 2'd1) ? 18 : (wl == 2'd2) ? 20 : 24;
  endfunction

  function automatic logic [23:0] sx(input logic [23:0] v, input logic [1:0] wl);
    int w = wbits(wl);
    logic [23:0] r = v;
    for (int i = 0; i < 24; i++) if (i >= w) r[i] = v[w-1];
    return r;
  endfunction

  task automatic send_bit(input logic d, input logic l);
    bclk_in = 1'b0;
    sdin = d;
    lrck_in = l;
    if ($urandom % 5 == 0) repeat ($urandom % 15) @(negedge clk);
    repeat (4) @(negedge clk);
    bclk_in = 1'b1;
    repeat (4) @(negedge clk);
    bclk_in = 1'b0;
  endtask

  task automatic send_frame(input logic [23:0] lv, input logic [23:0] rv);
    int w = wbits(wlen);
    for (int i = 0; i < 64; i++) begin
      logic d = 1'($urandom % 2);
      logic l;
      case (fmt)
        2'd0: begin
          l = (i < 32);
          if (i < w) d = lv[w-1-i];
          else if (i >= 32 && i - 32 < w) d = rv[w-1-(i-32)];
        end
        2'd1: begin
          l = (i >= 32);
          if (i >= 1 && i <= w) d = lv[w-i];
          else if (i >= 33 && i <= 32 + w) d = rv[w-(i-32)];
        end
        2'd2: begin
          l = (i < 32);
          if (i >= 32 - w && i < 32) d = lv[31-i];
          else if (i >= 64 - w) d = rv[63-i];
        end
        default: begin
          l = (i == 0);
          if (i >= 1 && i <= w) d = lv[w-i];
          else if (i > w && i <= 2 * w) d = rv[2*w-i];
        end
      endcase
      send_bit(d, l);
    end
  endtask

  task automatic do_reset(input logic [1:0] f, input logic [1:0] wl);
    rst_n = 1'b0;
    bclk_in = 1'b0;
    lrck_in = 1'b0;
    fmt = f;
    wlen = wl;
    repeat (6) @(negedge clk);
    chk("R11 reset out_left", out_left, 24'h0);
    chk("R11 reset out_right", out_right, 24'h0);
    chk("R11 reset flags/valid", {21'h0, out_valid, zero_left, zero_right}, 24'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_mode(input logic [1:0] f, input logic [1:0] wl, input int n);
    logic [23:0] pl = '0, pr = '0;
    string tags[4] = '{"R1", "R2", "R3", "R4"};
    int w = wbits(wl);
    do_reset(f, wl);
    send_frame(24'h0, 24'h0);
    repeat (12) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      logic [23:0] lv = 24'($urandom), rv = 24'($urandom);
      logic [23:0] el, er;
      int v0;
      if (k == 0) begin lv = 24'((1 << (w-1)) - 1); rv = 24'(1 << (w-1)); end
      if (k == 1) begin lv = 24'hFFFFFF; rv = 24'h000001; end
      v0 = vcnt;
      send_frame(lv, rv);
      repeat (12) @(negedge clk);
      el = (f == 2'd2) ? pl : sx(lv, wl);
      er = (f == 2'd2) ? pr : sx(rv, wl);
      chk($sformatf("%s R5 R6 R8 left fmt%0d wl%0d", tags[f], f, wl), out_left, el);
      chk($sformatf("%s R5 R6 R8 right fmt%0d wl%0d", tags[f], f, wl), out_right, er);
      chk($sformatf("R7 pulses fmt%0d wl%0d", f, wl), 24'(vcnt - v0), 24'd1);
      pl = sx(lv, wl);
      pr = sx(rv, wl);
    end
  endtask

  task automatic zero_frame(input logic [23:0] lv, inout int zc, input string tag);
    send_frame(lv, 24'($urandom) | 24'h1);
    repeat (12) @(negedge clk);
    zc = (lv[15:0] == 16'h0) ? zc + 1 : 0;
    chk(tag, {22'h0, zero_left, zero_right}, {22'h0, zc > ZR, 1'b0});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int zc;
    void'($urandom(32'd20240611));
    for (int f = 0; f < 4; f++)
      for (int wl = 0; wl < 4; wl++)
        run_mode(2'(f), 2'(wl), 5);

    do_reset(2'd0, 2'd0);
    zc = 0;
    send_frame(24'h0, 24'h1);
    repeat (12) @(negedge clk);
    zc = 1;
    for (int k = 0; k < 12; k++) zero_frame(24'hAB0000, zc, "R9 R6 zero flag run/saturate");
    zero_frame(24'h000005, zc, "R10 zero flag clears");
    for (int k = 0; k < 8; k++) zero_frame(24'h0, zc, "R9 zero flag rerun");
    chk("R9 flag high before reset", {23'h0, zero_left}, 24'h1);
    do_reset(2'd0, 2'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule